// File: doc/BRIEF.md
# Serial EEPROM Boot Image Loader

This block fills an on-chip code memory from a small serial EEPROM as soon as the chip leaves reset. Nobody has to start it or supply anything to it. It acts as a mode-0 SPI master. It pulls chip select low and sends the read opcode 0x03. It then sends start address 0x00 and clocks in the whole image in one unbroken burst, relying on the EEPROM's own address auto-increment. The image holds at most 256 bytes, because the EEPROM has an 8-bit address space.

Incoming bits are gathered straight into a word register. Every four bytes produce a single write on the code memory port, at consecutive word addresses starting from zero. When the last word has been written and chip select has gone high again, a done flag rises. It stays high until the next reset. The serial clock is the system clock divided by an even, parameterised ratio.

Top module: `boot_image_loader`

## Requirements
- R1: While reset is high the outputs are idle: cs_n_o=1, sck_o=0, mosi_o=0, code_we_o=0, done_o=0. Once reset is released, cs_n_o falls within 2 clock cycles without any other input.
- R2: On mosi_o, most significant bit first, the first 8 serial clock periods carry the opcode 0x03 and the next 8 periods carry the start address 0x00.
- R3: Mode 0 timing: mosi_o changes only while sck_o is low, and miso_i is sampled on each rising sck_o edge from serial period 16 onward.
- R4: A full sck_o period is CLK_DIV system clock cycles, with equal high and low halves.
- R5: One chip-select assertion covers the whole load. cs_n_o stays low for exactly 16 + 8*IMAGE_BYTES rising sck_o edges and then rises, with sck_o low.
- R6: Each group of four received bytes produces exactly one code_we_o pulse. The first byte of the group lands in bits 31:24 and the fourth in bits 7:0.
- R7: Word addresses start at 0 and rise by one per write, for IMAGE_BYTES/4 writes in total.
- R8: done_o rises only after the last write and after cs_n_o has gone high. It then stays high, with cs_n_o high, sck_o low and no further writes, until reset.
- R9: A reset in the middle of a load abandons it. After release the load starts again from EEPROM address 0x00 and word address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_o | output | 1 | Serial clock to the EEPROM |
| cs_n_o | output | 1 | EEPROM chip select, active low |
| mosi_o | output | 1 | Serial data to the EEPROM |
| miso_i | input | 1 | Serial data from the EEPROM |
| code_we_o | output | 1 | Code memory write strobe, one cycle per word |
| code_addr_o | output | ADDR_W | Code memory word address |
| code_wdata_o | output | 32 | Code memory write data |
| done_o | output | 1 | Load finished, held until reset |

## Verification
A bit counter that is off by one would show at the ports in two ways. The EEPROM model would receive an opcode or address other than 0x0300, and the count of clock edges under chip select would be wrong. Both show up within the first 16 serial periods or at chip-select release. Any slip in the word packer misaligns the bytes, so the very first write carries wrong data or a wrong address, about 48 serial periods after reset. A stuck or early state machine shows as done_o rising while chip select is still low, or as activity on the serial lines after done_o.

// File: rtl/bil_pkg.sv
package bil_pkg;
  localparam logic [7:0] READ_OPCODE = 8'h03;
  localparam logic [7:0] FIRST_ADDR  = 8'h00;
  localparam int unsigned HDR_BITS   = 16;

  typedef enum logic [1:0] {
    ST_START = 2'd0,
    ST_XFER  = 2'd1,
    ST_STOP  = 2'd2,
    ST_DONE  = 2'd3
  } ldr_state_t;
endpackage

// File: rtl/bil_sclk_gen.sv
module bil_sclk_gen #(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic sclk,
  output logic rise_p,
  output logic fall_p
);
  localparam int unsigned HALF = CLK_DIV / 2;

  logic tick;

  generate
    if (HALF <= 1) begin : g_nodiv
      assign tick = en;
    end else begin : g_div
      localparam int CW = $clog2(HALF);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst || !en)                 cnt <= '0;
        else if (cnt == CW'(HALF - 1))  cnt <= '0;
        else                            cnt <= cnt + 1'b1;
      end
      assign tick = en && (cnt == CW'(HALF - 1));
    end
  endgenerate

  assign rise_p = tick && !sclk;
  assign fall_p = tick && sclk;

  always_ff @(posedge clk) begin
    if (rst || !en) sclk <= 1'b0;
    else if (tick)  sclk <= ~sclk;
  end
endmodule

// File: rtl/bil_cmd_shifter.sv
module bil_cmd_shifter
  import bil_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic shift,
  output logic mosi
);
  logic [HDR_BITS-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)        sr <= '0;
    else if (load)  sr <= {READ_OPCODE, FIRST_ADDR};
    else if (shift) sr <= {sr[HDR_BITS-2:0], 1'b0};
  end

  assign mosi = sr[HDR_BITS-1];
endmodule

// File: rtl/bil_word_packer.sv
module bil_word_packer #(
  parameter int unsigned WORD_BITS = 32,
  parameter int unsigned ADDR_W    = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bit_vld,
  input  logic                 bit_val,
  output logic                 we_o,
  output logic [ADDR_W-1:0]    addr_o,
  output logic [WORD_BITS-1:0] data_o
);
  localparam int CW = $clog2(WORD_BITS);

  logic [CW-1:0]        bit_cnt;
  logic [WORD_BITS-2:0] sr;
  logic [ADDR_W-1:0]    next_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt   <= '0;
      sr        <= '0;
      next_addr <= '0;
      we_o      <= 1'b0;
      addr_o    <= '0;
      data_o    <= '0;
    end else begin
      we_o <= 1'b0;
      if (bit_vld) begin
        sr <= {sr[WORD_BITS-3:0], bit_val};
        if (bit_cnt == CW'(WORD_BITS - 1)) begin
          bit_cnt   <= '0;
          we_o      <= 1'b1;
          addr_o    <= next_addr;
          data_o    <= {sr, bit_val};
          next_addr <= next_addr + 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  // R6: writes are a whole word of serial bits apart, never back to back
  assert_write_spacing_R6: assert property (@(posedge clk) disable iff (rst)
    we_o |=> !we_o);

  // R7: consecutive writes use consecutive addresses
  assert_addr_step_R7: assert property (@(posedge clk) disable iff (rst)
    (we_o && addr_o != '0) |-> (next_addr == addr_o + 1'b1));
endmodule

// File: rtl/boot_image_loader.sv
module boot_image_loader
  import bil_pkg::*;
#(
  parameter int unsigned CLK_DIV        = 4,
  parameter int unsigned IMAGE_BYTES    = 256,
  parameter int unsigned BYTES_PER_WORD = 4,
  parameter int unsigned WORD_BITS      = 8 * BYTES_PER_WORD,
  parameter int unsigned WORDS          = IMAGE_BYTES / BYTES_PER_WORD,
  parameter int unsigned ADDR_W         = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic                 sck_o,
  output logic                 cs_n_o,
  output logic                 mosi_o,
  input  logic                 miso_i,
  output logic                 code_we_o,
  output logic [ADDR_W-1:0]    code_addr_o,
  output logic [WORD_BITS-1:0] code_wdata_o,
  output logic                 done_o
);
  localparam int unsigned TOTAL_BITS = HDR_BITS + 8 * IMAGE_BYTES;
  localparam int BCW = $clog2(TOTAL_BITS + 1);
  localparam logic [BCW-1:0] LAST_BIT  = BCW'(TOTAL_BITS - 1);
  localparam logic [BCW-1:0] DATA_FROM = BCW'(HDR_BITS);

  ldr_state_t     state;
  logic [BCW-1:0] bit_cnt;
  logic           rise_p, fall_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_START;
      cs_n_o  <= 1'b1;
      bit_cnt <= '0;
      done_o  <= 1'b0;
    end else begin
      unique case (state)
        ST_START: begin
          cs_n_o  <= 1'b0;
          bit_cnt <= '0;
          state   <= ST_XFER;
        end
        ST_XFER: begin
          if (fall_p) begin
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT) begin
              cs_n_o <= 1'b1;
              state  <= ST_STOP;
            end
          end
        end
        ST_STOP: begin
          done_o <= 1'b1;
          state  <= ST_DONE;
        end
        default: state <= ST_DONE;
      endcase
    end
  end

  bil_sclk_gen #(.CLK_DIV(CLK_DIV)) sclk_i (
    .clk    (clk),
    .rst    (rst),
    .en     (state == ST_XFER),
    .sclk   (sck_o),
    .rise_p (rise_p),
    .fall_p (fall_p)
  );

  bil_cmd_shifter cmd_i (
    .clk   (clk),
    .rst   (rst),
    .load  (state == ST_START),
    .shift (fall_p),
    .mosi  (mosi_o)
  );

  bil_word_packer #(.WORD_BITS(WORD_BITS), .ADDR_W(ADDR_W)) pack_i (
    .clk     (clk),
    .rst     (rst),
    .bit_vld (rise_p && (bit_cnt >= DATA_FROM)),
    .bit_val (miso_i),
    .we_o    (code_we_o),
    .addr_o  (code_addr_o),
    .data_o  (code_wdata_o)
  );

  // R3: serial output holds still while the serial clock is high
  assert_mosi_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (sck_o && $past(sck_o)) |-> $stable(mosi_o));

  // R5: chip select is released only with the serial clock low
  assert_cs_release_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n_o) |-> !sck_o);

  // R8: done follows chip-select release
  assert_done_after_cs_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> (cs_n_o && $past(cs_n_o)));

  // R8: done is sticky and the bus stays quiet
  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> (done_o && cs_n_o && !sck_o && !code_we_o));
endmodule

// File: tb/boot_image_loader_tb.sv
module boot_image_loader_tb_top;
  localparam int CLK_DIV     = 4;
  localparam int IMAGE_BYTES = 256;
  localparam int WORDS       = IMAGE_BYTES / 4;
  localparam int TOTAL_BITS  = 16 + 8 * IMAGE_BYTES;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sck_o, cs_n_o, mosi_o, code_we_o, done_o;
  logic        miso_i = 1'b0;
  logic [5:0]  code_addr_o;
  logic [31:0] code_wdata_o;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;   // 50 MHz

  boot_image_loader #(.CLK_DIV(CLK_DIV), .IMAGE_BYTES(IMAGE_BYTES)) dut_i (
    .clk(clk), .rst(rst), .sck_o(sck_o), .cs_n_o(cs_n_o), .mosi_o(mosi_o),
    .miso_i(miso_i), .code_we_o(code_we_o), .code_addr_o(code_addr_o),
    .code_wdata_o(code_wdata_o), .done_o(done_o)
  );

  function automatic logic [7:0] eep(int a);
    return 8'(((a * 29) + 7) ^ (a >> 3));
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- EEPROM model ----------------
  int          rise_cnt = 0;
  logic [15:0] hdr = '0;
  int          cyc = 0;
  int          last_rise = -1;
  int          period_bad = 0;

  always @(posedge clk) cyc++;

  always @(negedge cs_n_o) begin
    rise_cnt  = 0;
    hdr       = '0;
    last_rise = -1;
  end

  always @(posedge sck_o) begin
    if (!cs_n_o) begin
      if (rise_cnt < 16) hdr = {hdr[14:0], mosi_o};
      rise_cnt++;
      if (last_rise >= 0 && (cyc - last_rise) != CLK_DIV) period_bad++;
      last_rise = cyc;
    end
  end

  always @(negedge sck_o) begin
    if (!cs_n_o) begin
      if ((cyc - last_rise) != CLK_DIV / 2) period_bad++;
      if (rise_cnt >= 16) begin
        int k;
        logic [7:0] b;
        k = rise_cnt - 16;
        b = eep((int'(hdr[7:0]) + k / 8) % 256);
        miso_i = b[7 - (k % 8)];
      end
    end
  end

  // ---------------- write and line monitors ----------------
  int wr_cnt = 0;
  int mosi_bad = 0;
  int late_writes = 0;
  logic prev_sck = 1'b0, prev_mosi = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (sck_o && prev_sck && mosi_o != prev_mosi) mosi_bad++;
      if (code_we_o) begin
        logic [31:0] exp_w;
        if (done_o) late_writes++;
        exp_w = {eep(4*wr_cnt), eep(4*wr_cnt+1), eep(4*wr_cnt+2), eep(4*wr_cnt+3)};
        chk(code_addr_o == 6'(wr_cnt), "R7", "word address", code_addr_o, wr_cnt);
        // R3 sampling and R6 byte order both show in the word value
        chk(code_wdata_o == exp_w, "R6", "word data", code_wdata_o, exp_w);
        wr_cnt++;
      end
    end
    prev_sck  = sck_o;
    prev_mosi = mosi_o;
  end

  task automatic release_and_time_start();
    int n;
    @(negedge clk);
    rst = 1'b0;
    n = 0;
    while (cs_n_o && n < 10) begin
      @(negedge clk);
      n++;
    end
    chk(n >= 1 && n <= 2, "R1", "cycles to chip select", n, 2);
  endtask

  task automatic check_full_run(string tag);
    wait (done_o === 1'b1);
    @(negedge clk);
    chk(cs_n_o == 1'b1, "R8", {tag, " cs high at done"}, cs_n_o, 1);
    chk(wr_cnt == WORDS, "R7", {tag, " write count"}, wr_cnt, WORDS);
    chk(rise_cnt == TOTAL_BITS, "R5", {tag, " edges under cs"}, rise_cnt, TOTAL_BITS);
    chk(hdr == 16'h0300, "R2", {tag, " opcode and address"}, hdr, 16'h0300);
    chk(period_bad == 0, "R4", {tag, " clock timing errors"}, period_bad, 0);
    chk(mosi_bad == 0, "R3", {tag, " mosi moved while sck high"}, mosi_bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({cs_n_o, sck_o, mosi_o, code_we_o, done_o} == 5'b10000, "R1", "reset idle outputs",
        {cs_n_o, sck_o, mosi_o, code_we_o, done_o}, 5'b10000);

    release_and_time_start();
    check_full_run("run1");

    // R8: stays quiet after done
    begin
      int bad = 0;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (!done_o || !cs_n_o || sck_o) bad++;
      end
      chk(bad == 0, "R8", "idle after done", bad, 0);
      chk(late_writes == 0 && wr_cnt == WORDS, "R8", "no writes after done", wr_cnt, WORDS);
    end

    // R9: reset in the middle of a load
    @(negedge clk);
    rst = 1'b1;
    wr_cnt = 0;
    period_bad = 0;
    repeat (2) @(negedge clk);
    release_and_time_start();
    wait (wr_cnt == 3);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk({cs_n_o, sck_o, done_o, code_we_o} == 4'b1000, "R9", "abort state",
        {cs_n_o, sck_o, done_o, code_we_o}, 4'b1000);
    wr_cnt = 0;
    period_bad = 0;
    release_and_time_start();
    check_full_run("R9 restart");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule